// File: doc/BRIEF.md
# Transmit and Receive Descriptor Ring Sequencer

This block keeps a small table of buffer descriptors that a host fills and inspects over a 32-bit register bus. It walks two rings held in that table. The transmit ring starts at entry 0. The receive ring starts at the entry just after the last transmit entry. The split point is a programmable transmit count.

On the transmit side, the sequencer waits until the descriptor under its pointer is marked ready. It then passes the length, buffer address and per-frame pad and checksum options to a frame engine through a request/done handshake. When the engine reports completion, the block writes the engine's status flags into the descriptor, clears the ready mark, raises an event and moves on. On the receive side, the block shows the buffer address of the current descriptor. For each frame the engine reports, it either fills that descriptor with length and error flags or, if the descriptor is not free, drops the frame and pulses a busy event.

The frame datapath, buffer memory transfers and checksum logic are outside the block. Each appears only as a handshake port.

Top module: `bd_ring_sequencer`

## Requirements
- R1: After reset, `tx_req` and all five event outputs are 0. The transmit-count register at byte offset 0x000 reads 64. Every descriptor word reads 0, so `rx_avail` is 0.
- R2: Descriptor n occupies two words. Its status word is at byte offset 0x400 + 8·n and its buffer address word is at 0x400 + 8·n + 4. Both can be written with `reg_wr`. A `reg_rd` returns the word on `reg_rdata` one clock later.
- R3: A write to offset 0x000 sets the transmit count. Any value above 128 is stored as 128.
- R4: The transmit status word has these fields: bit 15 ready, bit 14 event enable, bit 13 wrap, bit 12 pad, bit 11 checksum, bits 8:0 completion flags, bits 31:16 length. When the descriptor under the transmit pointer has ready set, `tx_req` rises with `tx_len`, `tx_buf_addr`, `tx_pad` and `tx_crc` taken from it. `tx_req` stays high until `tx_done`.
- R5: On `tx_done`, the status word is rewritten. Ready is cleared, bits 8:0 take `tx_flags`, and the length and bits 14:9 keep their values.
- R6: A transmit completion with event enable set pulses `ev_tx_ok` for one cycle if `tx_flags` is zero, and `ev_tx_err` otherwise. With event enable clear, neither pulses.
- R7: The receive status word has these fields: bit 15 empty, bit 14 event enable, bit 13 wrap, bits 8:0 flags (bit 8 control frame, bits 7:0 errors), bits 31:16 length. `rx_avail` and `rx_buf_addr` show the current receive descriptor. On `rx_done` into an empty descriptor, the word becomes `rx_len` (including the 4-byte check sequence), empty cleared, bits 14:9 kept, and bits 8:0 set to `rx_flags`.
- R8: A receive fill with event enable set pulses `ev_rx_ok` when `rx_flags[7:0]` is zero, and `ev_rx_err` otherwise. The control-frame bit alone is not an error.
- R9: An `rx_done` whose current descriptor is not empty pulses `ev_busy`. It leaves the table and the receive pointer unchanged.
- R10: After a descriptor with wrap set, or after the last entry of its ring, each pointer returns to its ring's first entry: 0 for transmit, the transmit count for receive.
- R11: Writing the transmit count resets the transmit pointer to 0 and the receive pointer to the new count. It also drops any outstanding `tx_req` in the following cycle.
- R12: With a transmit count of 0, no transmit request is made. With a count of 128, no receive ring exists and every `rx_done` pulses `ev_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 12 | Host byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid the cycle after `reg_rd` |
| tx_req | output | 1 | Transmit request to the frame engine |
| tx_len | output | 16 | Frame length of the requested descriptor |
| tx_buf_addr | output | 32 | Buffer address of the requested descriptor |
| tx_pad | output | 1 | Pad option of the requested descriptor |
| tx_crc | output | 1 | Checksum option of the requested descriptor |
| tx_done | input | 1 | Engine finished the requested frame |
| tx_flags | input | 9 | Completion flags reported with `tx_done` |
| rx_avail | output | 1 | Current receive descriptor is empty |
| rx_buf_addr | output | 32 | Buffer address of the current receive descriptor |
| rx_done | input | 1 | Engine delivered a frame |
| rx_len | input | 16 | Received length including check sequence |
| rx_flags | input | 9 | Receive flags reported with `rx_done` |
| ev_tx_ok | output | 1 | Transmit completed cleanly |
| ev_tx_err | output | 1 | Transmit completed with flags |
| ev_rx_ok | output | 1 | Frame stored cleanly |
| ev_rx_err | output | 1 | Frame stored with error flags |
| ev_busy | output | 1 | Frame dropped, no free descriptor |

## Verification
A table of eight transmit descriptors is run through a four-entry ring. The table mixes clean and flagged completions, enabled and disabled events, pad and checksum options, one early wrap and one natural end of ring. A run with the wrong pointer order stalls or returns a wrong length, and a wrong write-back shows up in the read-back status.

The receive ring is tried with a clean frame, a frame with a checksum error, and a control-only frame. It is also tried with a frame arriving at an occupied descriptor, which separates the busy path from a fill. Count writes are tried while a request is outstanding, at the clamp boundary, and at both extremes, 0 and 128.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int ST_OWN  = 15;
    localparam int ST_IRQ  = 14;
    localparam int ST_WRAP = 13;
    localparam int ST_PAD  = 12;
    localparam int ST_CRC  = 11;
    localparam int FLAG_W  = 9;

    typedef enum logic {TX_IDLE, TX_BUSY} tx_state_e;

    typedef struct packed {
        logic [15:0] len;
        logic [31:0] addr;
        logic        pad;
        logic        crc;
    } tx_job_t;

    function automatic logic rx_is_error(input logic [FLAG_W-1:0] f);
        return |f[7:0];
    endfunction

    function automatic logic [31:0] pack_status(input logic [15:0] len,
                                                input logic [5:0] ctl,
                                                input logic [FLAG_W-1:0] flags);
        return {len, 1'b0, ctl, flags};
    endfunction

endpackage

// File: rtl/bd_table.sv
module bd_table
    import ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int IDXW     = $clog2(NUM_DESC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            host_we,
    input  logic [IDXW-1:0] host_idx,
    input  logic            host_word,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata,
    input  logic [IDXW-1:0] tx_idx,
    output logic [31:0]     tx_stat,
    output logic [31:0]     tx_addr,
    input  logic [IDXW-1:0] rx_idx,
    output logic [31:0]     rx_stat,
    output logic [31:0]     rx_addr,
    input  logic            tx_wb_en,
    input  logic [31:0]     tx_wb_data,
    input  logic            rx_wb_en,
    input  logic [31:0]     rx_wb_data
);

    logic [31:0] stat_mem [NUM_DESC];
    logic [31:0] addr_mem [NUM_DESC];

    assign host_rdata = host_word ? addr_mem[host_idx] : stat_mem[host_idx];
    assign tx_stat    = stat_mem[tx_idx];
    assign tx_addr    = addr_mem[tx_idx];
    assign rx_stat    = stat_mem[rx_idx];
    assign rx_addr    = addr_mem[rx_idx];

    // Later writes win: the host overrides an engine write-back to the same word.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                stat_mem[i] <= '0;
                addr_mem[i] <= '0;
            end
        end else begin
            if (tx_wb_en) stat_mem[tx_idx] <= tx_wb_data;
            if (rx_wb_en) stat_mem[rx_idx] <= rx_wb_data;
            if (host_we) begin
                if (host_word) addr_mem[host_idx] <= host_wdata;
                else           stat_mem[host_idx] <= host_wdata;
            end
        end
    end

endmodule

// File: rtl/tx_walker.sv
module tx_walker
    import ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int IDXW     = $clog2(NUM_DESC),
    parameter int CW       = $clog2(NUM_DESC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     tx_count,
    input  logic              cnt_wr,
    input  logic [31:9]       cur_stat,
    input  logic [31:0]       cur_addr,
    output logic [IDXW-1:0]   ptr,
    output logic              tx_req,
    output tx_job_t           job,
    input  logic              tx_done,
    input  logic [FLAG_W-1:0] tx_flags,
    output logic              wb_en,
    output logic [31:0]       wb_data,
    output logic              ev_ok,
    output logic              ev_err
);

    tx_state_e     st;
    logic [CW-1:0] last_ent;
    logic          at_end;
    logic          start;

    assign last_ent = tx_count - CW'(1);
    assign at_end   = cur_stat[ST_WRAP] || (CW'(ptr) == last_ent);
    assign start    = (st == TX_IDLE) && !cnt_wr && (tx_count != '0) && cur_stat[ST_OWN];
    assign wb_en    = (st == TX_BUSY) && tx_done && !cnt_wr;
    assign wb_data  = pack_status(cur_stat[31:16], cur_stat[14:9], tx_flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= TX_IDLE;
            ptr    <= '0;
            tx_req <= 1'b0;
            job    <= '0;
            ev_ok  <= 1'b0;
            ev_err <= 1'b0;
        end else begin
            ev_ok  <= 1'b0;
            ev_err <= 1'b0;
            if (cnt_wr) begin
                st     <= TX_IDLE;
                tx_req <= 1'b0;
                ptr    <= '0;
            end else begin
                case (st)
                    TX_IDLE: if (start) begin
                        st       <= TX_BUSY;
                        tx_req   <= 1'b1;
                        job.len  <= cur_stat[31:16];
                        job.addr <= cur_addr;
                        job.pad  <= cur_stat[ST_PAD];
                        job.crc  <= cur_stat[ST_CRC];
                    end
                    TX_BUSY: if (tx_done) begin
                        st     <= TX_IDLE;
                        tx_req <= 1'b0;
                        ev_ok  <= cur_stat[ST_IRQ] && (tx_flags == '0);
                        ev_err <= cur_stat[ST_IRQ] && (tx_flags != '0);
                        ptr    <= at_end ? '0 : ptr + IDXW'(1);
                    end
                    default: st <= TX_IDLE;
                endcase
            end
        end
    end

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_done && !cnt_wr) |=> tx_req);

    // R6
    tx_ev_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_ok || ev_err) |-> $past(tx_done && tx_req));

    // R10
    tx_ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count != '0) |-> (CW'(ptr) < tx_count));

    // R11
    tx_cnt_abort_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !tx_req);

endmodule

// File: rtl/rx_walker.sv
module rx_walker
    import ring_pkg::*;
#(
    parameter int NUM_DESC     = 128,
    parameter int IDXW         = $clog2(NUM_DESC),
    parameter int CW           = $clog2(NUM_DESC + 1),
    parameter int TX_COUNT_RST = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     tx_count,
    input  logic              cnt_wr,
    input  logic [IDXW-1:0]   new_first,
    input  logic [15:9]       cur_ctl,
    output logic [IDXW-1:0]   ptr,
    output logic              avail,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [FLAG_W-1:0] rx_flags,
    output logic              wb_en,
    output logic [31:0]       wb_data,
    output logic              ev_ok,
    output logic              ev_err,
    output logic              ev_busy
);

    logic ring_ok;
    logic at_end;
    logic take;

    assign ring_ok = tx_count < CW'(NUM_DESC);
    assign at_end  = cur_ctl[ST_WRAP] || (ptr == IDXW'(NUM_DESC - 1));
    assign avail   = ring_ok && cur_ctl[ST_OWN];
    assign take    = rx_done && avail;
    assign wb_en   = take;
    assign wb_data = pack_status(rx_len, cur_ctl[14:9], rx_flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= IDXW'(TX_COUNT_RST);
            ev_ok   <= 1'b0;
            ev_err  <= 1'b0;
            ev_busy <= 1'b0;
        end else begin
            ev_ok   <= take && cur_ctl[ST_IRQ] && !rx_is_error(rx_flags);
            ev_err  <= take && cur_ctl[ST_IRQ] && rx_is_error(rx_flags);
            ev_busy <= rx_done && !take;
            if (cnt_wr)    ptr <= new_first;
            else if (take) ptr <= at_end ? tx_count[IDXW-1:0] : ptr + IDXW'(1);
        end
    end

    // R9
    rx_busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ev_busy |-> $past(rx_done));

    // R10
    rx_ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ring_ok |-> (CW'(ptr) >= tx_count));

    // R8
    rx_ev_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_ok, ev_err, ev_busy}));

endmodule

// File: rtl/bd_ring_sequencer.sv
module bd_ring_sequencer
    import ring_pkg::*;
#(
    parameter int          NUM_DESC     = 128,
    parameter int          AW           = 12,
    parameter logic [31:0] TABLE_BASE   = 32'h400,
    parameter logic [31:0] CNT_OFFSET   = 32'h000,
    parameter int          TX_COUNT_RST = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          tx_req,
    output logic [15:0]   tx_len,
    output logic [31:0]   tx_buf_addr,
    output logic          tx_pad,
    output logic          tx_crc,
    input  logic          tx_done,
    input  logic [8:0]    tx_flags,
    output logic          rx_avail,
    output logic [31:0]   rx_buf_addr,
    input  logic          rx_done,
    input  logic [15:0]   rx_len,
    input  logic [8:0]    rx_flags,
    output logic          ev_tx_ok,
    output logic          ev_tx_err,
    output logic          ev_rx_ok,
    output logic          ev_rx_err,
    output logic          ev_busy
);

    localparam int          IDXW = $clog2(NUM_DESC);
    localparam int          CW   = $clog2(NUM_DESC + 1);
    localparam logic [31:0] SPAN = 32'(NUM_DESC * 8);

    logic [31:0]     a32;
    logic            tbl_hit, cnt_hit, cnt_wr;
    logic [CW-1:0]   tx_count, cnt_new;
    logic [IDXW-1:0] host_idx, tx_ptr, rx_ptr;
    logic [31:0]     host_rdata, tx_stat, tx_addr_w, rx_stat;
    logic            tx_wb_en, rx_wb_en;
    logic [31:0]     tx_wb_data, rx_wb_data;
    tx_job_t         job;

    assign a32      = 32'(reg_addr);
    assign tbl_hit  = (a32 >= TABLE_BASE) && (a32 < TABLE_BASE + SPAN) && (a32[1:0] == 2'b00);
    assign cnt_hit  = (a32 == CNT_OFFSET);
    assign host_idx = IDXW'((a32 - TABLE_BASE) >> 3);
    assign cnt_wr   = reg_wr && cnt_hit;
    assign cnt_new  = (reg_wdata > 32'(NUM_DESC)) ? CW'(NUM_DESC) : reg_wdata[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_count  <= CW'(TX_COUNT_RST);
            reg_rdata <= '0;
        end else begin
            if (cnt_wr) tx_count <= cnt_new;
            if (reg_rd) begin
                if (tbl_hit)      reg_rdata <= host_rdata;
                else if (cnt_hit) reg_rdata <= 32'(tx_count);
                else              reg_rdata <= '0;
            end
        end
    end

    bd_table #(.NUM_DESC(NUM_DESC), .IDXW(IDXW)) u_table (
        .clk, .rst,
        .host_we   (reg_wr && tbl_hit),
        .host_idx  (host_idx),
        .host_word (a32[2]),
        .host_wdata(reg_wdata),
        .host_rdata(host_rdata),
        .tx_idx    (tx_ptr),
        .tx_stat   (tx_stat),
        .tx_addr   (tx_addr_w),
        .rx_idx    (rx_ptr),
        .rx_stat   (rx_stat),
        .rx_addr   (rx_buf_addr),
        .tx_wb_en  (tx_wb_en),
        .tx_wb_data(tx_wb_data),
        .rx_wb_en  (rx_wb_en),
        .rx_wb_data(rx_wb_data)
    );

    tx_walker #(.NUM_DESC(NUM_DESC), .IDXW(IDXW), .CW(CW)) u_tx (
        .clk, .rst,
        .tx_count(tx_count),
        .cnt_wr  (cnt_wr),
        .cur_stat(tx_stat[31:9]),
        .cur_addr(tx_addr_w),
        .ptr     (tx_ptr),
        .tx_req  (tx_req),
        .job     (job),
        .tx_done (tx_done),
        .tx_flags(tx_flags),
        .wb_en   (tx_wb_en),
        .wb_data (tx_wb_data),
        .ev_ok   (ev_tx_ok),
        .ev_err  (ev_tx_err)
    );

    rx_walker #(.NUM_DESC(NUM_DESC), .IDXW(IDXW), .CW(CW), .TX_COUNT_RST(TX_COUNT_RST)) u_rx (
        .clk, .rst,
        .tx_count (tx_count),
        .cnt_wr   (cnt_wr),
        .new_first(cnt_new[IDXW-1:0]),
        .cur_ctl  (rx_stat[15:9]),
        .ptr      (rx_ptr),
        .avail    (rx_avail),
        .rx_done  (rx_done),
        .rx_len   (rx_len),
        .rx_flags (rx_flags),
        .wb_en    (rx_wb_en),
        .wb_data  (rx_wb_data),
        .ev_ok    (ev_rx_ok),
        .ev_err   (ev_rx_err),
        .ev_busy  (ev_busy)
    );

    assign tx_len      = job.len;
    assign tx_buf_addr = job.addr;
    assign tx_pad      = job.pad;
    assign tx_crc      = job.crc;

    // R3
    cnt_max_chk: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CW'(NUM_DESC));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_rd) |-> $stable(reg_rdata));

endmodule

// File: tb/bd_ring_sequencer_test.sv
`timescale 1ns/1ps
module bd_ring_sequencer_test;

    typedef struct packed {
        logic [6:0]  idx;
        logic [15:0] len;
        logic [31:0] addr;
        logic        irq;
        logic        wrap;
        logic        pad;
        logic        crc;
        logic [8:0]  flags;
    } txv_t;

    localparam txv_t TXV [8] = '{
        '{7'd0, 16'd60,   32'h1000, 1'b1, 1'b0, 1'b1, 1'b1, 9'h000},
        '{7'd1, 16'd1500, 32'h1600, 1'b1, 1'b0, 1'b0, 1'b1, 9'h108},
        '{7'd2, 16'd64,   32'h1C00, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000},
        '{7'd0, 16'd128,  32'h2200, 1'b1, 1'b0, 1'b0, 1'b1, 9'h030},
        '{7'd1, 16'd256,  32'h2800, 1'b1, 1'b0, 1'b1, 1'b0, 9'h000},
        '{7'd2, 16'd512,  32'h2E00, 1'b1, 1'b0, 1'b0, 1'b0, 9'h004},
        '{7'd3, 16'd1000, 32'h3400, 1'b1, 1'b0, 1'b0, 1'b1, 9'h000},
        '{7'd0, 16'd42,   32'h3A00, 1'b0, 1'b0, 1'b1, 1'b1, 9'h001}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_req, tx_pad, tx_crc;
    logic [15:0] tx_len;
    logic [31:0] tx_buf_addr;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_flags = '0;
    logic        rx_avail;
    logic [31:0] rx_buf_addr;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_flags = '0;
    logic        ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    bd_ring_sequencer uut (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    function automatic logic [11:0] st_a(input int n);
        return 12'(32'h400 + 8 * n);
    endfunction

    task automatic wait_req(input string tag);
        for (int i = 0; i < 10 && !tx_req; i++) tick();
        check(tag, 32'(tx_req), 32'd1);
    endtask

    task automatic rx_frame(input logic [15:0] len, input logic [8:0] fl);
        rx_done = 1'b1; rx_len = len; rx_flags = fl;
        tick();
        rx_done = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        eok, eerr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 tx_req", 32'(tx_req), 0);
        check("R1 events", 32'({ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_busy}), 0);
        check("R1 rx_avail", 32'(rx_avail), 0);
        read_reg(12'h000, d); check("R1 count", d, 64);
        read_reg(st_a(0), d); check("R1 status word", d, 0);

        // R3 clamp, R12 no receive ring at 128
        write_reg(12'h000, 200);
        read_reg(12'h000, d); check("R3 clamp 200", d, 128);
        rx_frame(16'd80, 9'h000);
        check("R12 busy at 128", 32'(ev_busy), 1);
        write_reg(12'h000, 4);
        read_reg(12'h000, d); check("R3 count 4", d, 4);

        // R2 address word access
        write_reg(st_a(9) + 12'd4, 32'hDEADBEEF);
        read_reg(st_a(9) + 12'd4, d); check("R2 addr word", d, 32'hDEADBEEF);

        // R4 R5 R6 R10 transmit vector table
        foreach (TXV[k]) begin
            write_reg(st_a(TXV[k].idx) + 12'd4, TXV[k].addr);
            write_reg(st_a(TXV[k].idx), {TXV[k].len, 1'b1, TXV[k].irq, TXV[k].wrap,
                                          TXV[k].pad, TXV[k].crc, 2'b00, 9'h000});
            wait_req($sformatf("R10 request vec %0d", k));
            check($sformatf("R4 len vec %0d", k), 32'(tx_len), 32'(TXV[k].len));
            check($sformatf("R4 addr vec %0d", k), tx_buf_addr, TXV[k].addr);
            check($sformatf("R4 opts vec %0d", k), 32'({tx_pad, tx_crc}), 32'({TXV[k].pad, TXV[k].crc}));
            tick();
            check($sformatf("R4 hold vec %0d", k), 32'(tx_req), 1);
            tx_done = 1'b1; tx_flags = TXV[k].flags;
            tick();
            tx_done = 1'b0; tx_flags = '0;
            eok  = TXV[k].irq && (TXV[k].flags == 0);
            eerr = TXV[k].irq && (TXV[k].flags != 0);
            check($sformatf("R6 events vec %0d", k), 32'({ev_tx_ok, ev_tx_err}), 32'({eok, eerr}));
            check($sformatf("R4 req drop vec %0d", k), 32'(tx_req), 0);
            read_reg(st_a(TXV[k].idx), d);
            check($sformatf("R5 writeback vec %0d", k), d,
                  {TXV[k].len, 1'b0, TXV[k].irq, TXV[k].wrap, TXV[k].pad, TXV[k].crc, 2'b00, TXV[k].flags});
        end

        // R7 R8 R9 R10 receive ring (first entry 4)
        write_reg(st_a(4) + 12'd4, 32'hA000);
        write_reg(st_a(4), 32'h0000C000);
        write_reg(st_a(5) + 12'd4, 32'hB000);
        write_reg(st_a(5), 32'h0000E000);
        check("R7 rx_avail", 32'(rx_avail), 1);
        check("R7 rx_buf_addr", rx_buf_addr, 32'hA000);
        rx_frame(16'd68, 9'h000);
        check("R8 clean frame", 32'({ev_rx_ok, ev_rx_err, ev_busy}), 32'b100);
        read_reg(st_a(4), d); check("R7 fill status", d, 32'h00444000);
        check("R10 rx advance", rx_buf_addr, 32'hB000);
        rx_frame(16'd100, 9'h002);
        check("R8 crc error frame", 32'({ev_rx_ok, ev_rx_err, ev_busy}), 32'b010);
        read_reg(st_a(5), d); check("R7 fill status err", d, 32'h00646002);
        check("R10 rx wrap", rx_buf_addr, 32'hA000);
        check("R9 not avail", 32'(rx_avail), 0);
        rx_frame(16'd50, 9'h000);
        check("R9 busy pulse", 32'({ev_rx_ok, ev_rx_err, ev_busy}), 32'b001);
        read_reg(st_a(4), d); check("R9 table unchanged", d, 32'h00444000);
        check("R9 pointer kept", rx_buf_addr, 32'hA000);
        write_reg(st_a(4), 32'h0000C000);
        rx_frame(16'd70, 9'h100);
        check("R8 control frame ok", 32'({ev_rx_ok, ev_rx_err, ev_busy}), 32'b100);
        read_reg(st_a(4), d); check("R7 control status", d, 32'h00464100);
        check("R10 rx at entry 5", rx_buf_addr, 32'hB000);

        // R11 count write aborts request and resets pointers (tx pointer at 1)
        write_reg(12'h000, 4);
        write_reg(st_a(0) + 12'd4, 32'h5000);
        write_reg(st_a(0), {16'd77, 16'h8000});
        wait_req("R11 first request");
        write_reg(12'h000, 4);
        check("R11 request dropped", 32'(tx_req), 0);
        check("R11 rx pointer reset", rx_buf_addr, 32'hA000);
        wait_req("R11 re-request");
        check("R11 same descriptor", 32'(tx_len), 77);
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        check("R6 no event irq clear", 32'({ev_tx_ok, ev_tx_err}), 0);

        // R12 empty transmit ring
        write_reg(12'h000, 0);
        write_reg(st_a(0), {16'd90, 16'h8000});
        repeat (6) tick();
        check("R12 no request at 0", 32'(tx_req), 0);

        report();
        $finish;
    end

endmodule